// File: doc/BRIEF.md
# Bus Illegal-Access Error Recorder

This block sits beside a bus slave port and keeps a record of illegal accesses that upstream decode logic has already identified. Each reported event arrives as a one-cycle strobe together with the full offending address and a flag saying whether the access was a read. The block is always ready to take an event, so the event input has no back-pressure and a strobe is never lost. The first event after the status is clean raises an error flag and latches the request details. Any further event raises a second flag that means more than one access went wrong, and it leaves the latched details as they were.

Software talks to the block through a plain 32-bit register port, with single-cycle writes and a combinational read. It reads the status and the latched request. It clears the flags by writing back the value it read, because each status bit is cleared when a 1 is written to it. A full-word mask register decides which status bits drive the interrupt line. The mask resets to all ones, so the interrupt starts disabled.

Top module: `bus_err_status`

## Requirements
- R1: After reset the status reads 0, the mask at offset 0x04 reads 0xFFFFFFFF, both request-info words read 0, and irq is low.
- R2: An event strobe while status bit 0 is clear sets status bit 0 (offset 0x00). It also latches the lower 32 address bits into the word at 0x08. The word at 0x0C holds address bits [41:32] in its bits [31:22] and the access type in bit 0, where 1 is a read and 0 is a write.
- R3: An event strobe while status bit 0 is set sets status bit 1 and leaves both request-info words unchanged.
- R4: A write to offset 0x00 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R5: The mask at 0x04 is a 32-bit read/write register. irq is high exactly when some status bit i is set while mask bit i is 0.
- R6: If an event strobe and a write that clears status bit 0 fall in the same cycle, status bit 0 stays set and the request-info words take the new event's address and type.
- R7: Writes to offsets 0x08 and 0x0C have no effect, and reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return 0.
- R8: A status bit only becomes set on the clock edge that samples an event strobe; the status read at 0x00 is unchanged before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | One-cycle strobe reporting an illegal access, always accepted |
| err_read | input | 1 | 1 when the reported access was a read |
| err_addr | input | 42 | Address of the reported access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Error interrupt |

## Verification
On every cycle, the assertions check these properties: an event always leaves the error flag set, the latched request stays stable while the flag is held, a clear of the multiple flag takes effect, no flag appears without an event, and irq is silent under a full mask. The bench scenarios show the things a cycle-local property cannot see. These are the exact address packing in the two info words, the ignored writes to read-only offsets and the zero read of unmapped offsets. The bench also covers the race between a clear and a new event, where it confirms that fresh request data was captured.

// File: rtl/bes_pkg.sv
package bes_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned FLAG_W = 2;

  localparam logic [OFF_W-1:0] OFF_STATUS  = 4'h0;
  localparam logic [OFF_W-1:0] OFF_MASK    = 4'h4;
  localparam logic [OFF_W-1:0] OFF_INFO_LO = 4'h8;
  localparam logic [OFF_W-1:0] OFF_INFO_HI = 4'hC;

  localparam int unsigned FLAG_ONE  = 0;
  localparam int unsigned FLAG_MANY = 1;

  typedef struct packed {
    logic [REG_W-1:0] lo;
    logic [REG_W-1:0] hi;
  } req_info_t;
endpackage

// File: rtl/bes_capture.sv
module bes_capture
  import bes_pkg::*;
#(
  parameter int unsigned ADDR_W = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic              err_read,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [FLAG_W-1:0] clr_bits,
  output logic [FLAG_W-1:0] status,
  output req_info_t         info
);
  localparam int unsigned HI_W  = ADDR_W - REG_W;
  localparam int unsigned PAD_W = REG_W - HI_W - 1;

  logic [FLAG_W-1:0] status_q, kept, status_d;
  req_info_t         info_q, info_d;
  logic              first_evt;

  always_comb begin
    kept      = status_q & ~clr_bits;
    first_evt = err_valid & ~kept[FLAG_ONE];
    status_d  = kept;
    if (err_valid) begin
      status_d[FLAG_ONE] = 1'b1;
      if (kept[FLAG_ONE]) status_d[FLAG_MANY] = 1'b1;
    end
    info_d = info_q;
    if (first_evt) begin
      info_d.lo = err_addr[REG_W-1:0];
      info_d.hi = {err_addr[ADDR_W-1:REG_W], {PAD_W{1'b0}}, err_read};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      info_q   <= '0;
    end else begin
      status_q <= status_d;
      info_q   <= info_d;
    end
  end

  assign status = status_q;
  assign info   = info_q;
endmodule

// File: rtl/bes_regfile.sv
module bes_regfile
  import bes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [FLAG_W-1:0] status,
  input  req_info_t         info,
  output logic [FLAG_W-1:0] clr_bits,
  output logic [REG_W-1:0]  mask,
  output logic [REG_W-1:0]  reg_rdata
);
  logic [REG_W-1:0] mask_q;
  logic             hit_status, hit_mask;

  assign hit_status = reg_wr && (reg_addr == OFF_STATUS);
  assign hit_mask   = reg_wr && (reg_addr == OFF_MASK);
  assign clr_bits   = hit_status ? reg_wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else if (hit_mask) mask_q <= reg_wdata;
  end

  always_comb begin
    unique case (reg_addr)
      OFF_STATUS:  reg_rdata = {{(REG_W-FLAG_W){1'b0}}, status};
      OFF_MASK:    reg_rdata = mask_q;
      OFF_INFO_LO: reg_rdata = info.lo;
      OFF_INFO_HI: reg_rdata = info.hi;
      default:     reg_rdata = '0;
    endcase
  end

  assign mask = mask_q;
endmodule

// File: rtl/bes_irq.sv
module bes_irq
  import bes_pkg::*;
(
  input  logic [FLAG_W-1:0] status,
  input  logic [REG_W-1:0]  mask,
  output logic              irq
);
  logic [FLAG_W-1:0] live;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_live
    assign live[i] = status[i] & ~mask[i];
  end

  assign irq = |live;
endmodule

// File: rtl/bus_err_status.sv
module bus_err_status
  import bes_pkg::*;
#(
  parameter int unsigned ADDR_W = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic              err_read,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic [FLAG_W-1:0] status_q;
  logic [FLAG_W-1:0] clr_bits;
  logic [REG_W-1:0]  mask_q;
  req_info_t         info_q;

  bes_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .err_read  (err_read),
    .err_addr  (err_addr),
    .clr_bits  (clr_bits),
    .status    (status_q),
    .info      (info_q)
  );

  bes_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .status    (status_q),
    .info      (info_q),
    .clr_bits  (clr_bits),
    .mask      (mask_q),
    .reg_rdata (reg_rdata)
  );

  bes_irq u_irq (
    .status (status_q),
    .mask   (mask_q),
    .irq    (irq)
  );
endmodule

// File: rtl/bes_checker.sv
module bes_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        err_valid,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [1:0]  status,
  input logic [31:0] mask,
  input logic [63:0] info,
  input logic        irq
);
  logic clr_one, clr_many;
  assign clr_one  = reg_wr && reg_addr == 4'h0 && reg_wdata[0];
  assign clr_many = reg_wr && reg_addr == 4'h0 && reg_wdata[1];

  AST_EVENT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> status[0]); // R2

  AST_INFO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !clr_one) |=> $stable(info)); // R3

  AST_MANY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_many && !err_valid) |=> !status[1]); // R4

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 32'hFFFF_FFFF) |-> !irq); // R5

  AST_IRQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !mask[0]) |-> irq); // R5

  AST_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && clr_one) |=> status[0]); // R6

  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> ((status & ~$past(status)) == 2'b00)); // R8
endmodule

bind bus_err_status bes_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_valid (err_valid),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .status    (status_q),
  .mask      (mask_q),
  .info      (info_q),
  .irq       (irq)
);

// File: tb/bus_err_status_test.sv
`timescale 1ns/1ps
module bus_err_status_test;
  localparam int ADDR_W = 42;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              err_valid = 1'b0;
  logic              err_read = 1'b0;
  logic [ADDR_W-1:0] err_addr = '0;
  logic              reg_wr = 1'b0;
  logic [3:0]        reg_addr = 4'h0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              irq;

  int applied = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bus_err_status #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_read(err_read),
    .err_addr(err_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // kind: 0 read-and-compare, 1 register write, 2 error event
  typedef struct packed {
    logic [1:0]  kind;
    logic        rd;
    logic [9:0]  hi;
    logic [3:0]  off;
    logic [31:0] data;
    logic [31:0] exp;
    logic        eirq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 10'h000, 4'h0, 32'h0,          32'h0,          1'b0, 4'd1}, // R1
    '{2'd0, 1'b0, 10'h000, 4'h4, 32'h0,          32'hFFFF_FFFF,  1'b0, 4'd1}, // R1
    '{2'd0, 1'b0, 10'h000, 4'h8, 32'h0,          32'h0,          1'b0, 4'd1}, // R1
    '{2'd2, 1'b1, 10'h155, 4'h0, 32'h1234_5678,  32'h0,          1'b0, 4'd2}, // R2
    '{2'd0, 1'b0, 10'h000, 4'h0, 32'h0,          32'h1,          1'b0, 4'd2},
    '{2'd0, 1'b0, 10'h000, 4'h8, 32'h0,          32'h1234_5678,  1'b0, 4'd2},
    '{2'd0, 1'b0, 10'h000, 4'hC, 32'h0,          32'h5540_0001,  1'b0, 4'd2},
    '{2'd2, 1'b0, 10'h3FF, 4'h0, 32'hDEAD_BEEF,  32'h0,          1'b0, 4'd3}, // R3
    '{2'd0, 1'b0, 10'h000, 4'h0, 32'h0,          32'h3,          1'b0, 4'd3},
    '{2'd0, 1'b0, 10'h000, 4'h8, 32'h0,          32'h1234_5678,  1'b0, 4'd3},
    '{2'd0, 1'b0, 10'h000, 4'hC, 32'h0,          32'h5540_0001,  1'b0, 4'd3},
    '{2'd1, 1'b0, 10'h000, 4'h4, 32'hFFFF_FFFE,  32'h0,          1'b1, 4'd5}, // R5
    '{2'd0, 1'b0, 10'h000, 4'h4, 32'h0,          32'hFFFF_FFFE,  1'b1, 4'd5},
    '{2'd1, 1'b0, 10'h000, 4'h0, 32'h1,          32'h0,          1'b0, 4'd4}, // R4
    '{2'd0, 1'b0, 10'h000, 4'h0, 32'h0,          32'h2,          1'b0, 4'd4},
    '{2'd1, 1'b0, 10'h000, 4'h4, 32'hFFFF_FFFD,  32'h0,          1'b1, 4'd5},
    '{2'd0, 1'b0, 10'h000, 4'h0, 32'h0,          32'h2,          1'b1, 4'd5},
    '{2'd1, 1'b0, 10'h000, 4'h0, 32'h0,          32'h0,          1'b1, 4'd4},
    '{2'd0, 1'b0, 10'h000, 4'h0, 32'h0,          32'h2,          1'b1, 4'd4},
    '{2'd1, 1'b0, 10'h000, 4'h0, 32'h2,          32'h0,          1'b0, 4'd4},
    '{2'd0, 1'b0, 10'h000, 4'h0, 32'h0,          32'h0,          1'b0, 4'd4},
    '{2'd1, 1'b0, 10'h000, 4'h8, 32'hFFFF_FFFF,  32'h0,          1'b0, 4'd7}, // R7
    '{2'd0, 1'b0, 10'h000, 4'h8, 32'h0,          32'h1234_5678,  1'b0, 4'd7},
    '{2'd1, 1'b0, 10'h000, 4'hC, 32'h0,          32'h0,          1'b0, 4'd7},
    '{2'd0, 1'b0, 10'h000, 4'hC, 32'h0,          32'h5540_0001,  1'b0, 4'd7},
    '{2'd0, 1'b0, 10'h000, 4'h1, 32'h0,          32'h0,          1'b0, 4'd7},
    '{2'd2, 1'b0, 10'h001, 4'h0, 32'h0000_0040,  32'h0,          1'b0, 4'd2},
    '{2'd0, 1'b0, 10'h000, 4'hC, 32'h0,          32'h0040_0000,  1'b0, 4'd2},
    '{2'd0, 1'b0, 10'h000, 4'h8, 32'h0,          32'h0000_0040,  1'b0, 4'd2},
    '{2'd0, 1'b0, 10'h000, 4'h0, 32'h0,          32'h1,          1'b0, 4'd2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [3:0] off, input logic [31:0] exp);
    reg_addr = off;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
      case (VECS[i].kind)
        2'd0: begin
          reg_addr = VECS[i].off;
          #1;
          check(tag, reg_rdata, VECS[i].exp);
        end
        2'd1: begin
          reg_wr = 1'b1; reg_addr = VECS[i].off; reg_wdata = VECS[i].data;
          @(posedge clk); #1;
          reg_wr = 1'b0;
        end
        default: begin
          err_valid = 1'b1; err_read = VECS[i].rd;
          err_addr = {VECS[i].hi, VECS[i].data};
          @(posedge clk); #1;
          err_valid = 1'b0;
        end
      endcase
      check({tag, " irq"}, {31'b0, irq}, {31'b0, VECS[i].eirq});
    end

    // R6: clear of bit 0 and a new event in the same cycle
    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h1;
    err_valid = 1'b1; err_read = 1'b1; err_addr = {10'h2AA, 32'hCAFE_0000};
    @(posedge clk); #1;
    reg_wr = 1'b0; err_valid = 1'b0;
    read_chk("R6 status", 4'h0, 32'h1);
    read_chk("R6 info lo", 4'h8, 32'hCAFE_0000);
    read_chk("R6 info hi", 4'hC, 32'hAA80_0001);

    // R8: status unchanged before the sampling edge, set after it
    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h3;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    err_valid = 1'b1; err_read = 1'b0; err_addr = {10'h001, 32'h0000_0080};
    read_chk("R8 before edge", 4'h0, 32'h0);
    @(posedge clk); #1;
    err_valid = 1'b0;
    read_chk("R8 after edge", 4'h0, 32'h1);

    // R1: reset in the middle of activity
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    read_chk("R1 status after reset", 4'h0, 32'h0);
    read_chk("R1 mask after reset", 4'h4, 32'hFFFF_FFFF);
    read_chk("R1 info hi after reset", 4'hC, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule